// File: doc/BRIEF.md
# Complex Baseband DC Offset Canceller

This block strips the slowly wandering DC bias from a stream of complex baseband samples. The in-phase and quadrature rails each carry their own bias, so each rail gets its own estimator. The estimator is a single-pole low-pass recursion whose pole sits at 1 - 2^-10 (about 0.999). It follows only near-DC drift. Every incoming sample has the integer part of its rail's current estimate subtracted, and the result is clamped to the 14-bit signed range.

A single enable input selects correction or exact pass-through. The estimators keep learning on every valid sample even while correction is off, so turning correction on produces no settling transient. Results appear one clock after the input sample, with a matching valid strobe.

Top module: `dc_offset_canceller`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and it is low after reset.
- R2: With `en` low, `out_i`/`out_q` equal the `in_i`/`in_q` sampled one clock earlier, bit for bit.
- R3: Each rail keeps a signed accumulator A holding the estimate scaled by 2^10. On every clock with `in_valid` high, A becomes A + floor((x*1024 - A) / 1024), where x is the 14-bit two's-complement input. This update happens whatever the state of `en`. Clocks with `in_valid` low leave A unchanged.
- R4: With `en` high, the output is x - floor(A/1024), using A as it stood before that sample's update. Under a constant input the output therefore settles to 0 or +1.
- R5: An enabled output above +8191 is clamped to 8191 (0x1FFF), and one below -8192 is clamped to -8192 (0x2000).
- R6: The I and Q rails have separate accumulators, and neither rail's input affects the other rail's output.
- R7: Reset clears both accumulators, so the first enabled sample after reset comes out equal to its input.
- R8: While `in_valid` is low, `out_i` and `out_q` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | High: subtract the estimate; low: pass samples through unchanged |
| in_valid | input | 1 | Marks a new sample pair on `in_i`/`in_q` |
| in_i | input | 14 | In-phase sample, two's complement |
| in_q | input | 14 | Quadrature sample, two's complement |
| out_valid | output | 1 | Marks a result pair on `out_i`/`out_q` |
| out_i | output | 14 | Corrected in-phase sample |
| out_q | output | 14 | Corrected quadrature sample |

## Verification
Assertions check the following properties on every cycle:
- the one-clock alignment of `out_valid` to `in_valid`;
- exact pass-through on both rails whenever correction was off for a valid sample;
- that output data holds through cycles with no valid input.

Some behaviour needs a bit-exact model of the fixed-point recursion driven over thousands of samples, so only the bench scenarios can show it:
- the estimate values and convergence to within one count;
- clamping at both range limits after the estimate has been pulled to the opposite rail;
- learning that continues while correction is disabled;
- independence of the two rails;
- the accumulator clear on reset.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    // Rail index for the complex sample pair
    typedef enum logic {
        RAIL_I = 1'b0,
        RAIL_Q = 1'b1
    } rail_e;

    localparam int unsigned NUM_RAILS = 2;
endpackage

// File: rtl/dcc_rail.sv
// One rail: leaky estimator of the DC bias plus subtract-and-clamp output stage.
module dcc_rail #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned SHIFT    = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp,
    output logic [SAMPLE_W-1:0] res
);
    localparam int unsigned ACC_W = SAMPLE_W + SHIFT;
    localparam int unsigned EXT_W = ACC_W + 1;
    localparam int unsigned SUB_W = SAMPLE_W + 1;

    typedef struct packed {
        logic signed [ACC_W-1:0]    acc;
        logic        [SAMPLE_W-1:0] res;
    } rail_st_t;

    rail_st_t st_d, st_q;

    logic signed [EXT_W-1:0] x_scaled;
    logic signed [EXT_W-1:0] acc_ext;
    logic signed [EXT_W-1:0] err;
    logic signed [EXT_W-1:0] step;
    logic signed [EXT_W-1:0] acc_sum;
    logic signed [ACC_W-1:0] est_full;
    logic signed [SUB_W-1:0] est;
    logic signed [SUB_W-1:0] x_wide;
    logic signed [SUB_W-1:0] diff;
    logic        [SAMPLE_W-1:0] clamped;

    always_comb begin
        st_d = st_q;

        // Estimator update: acc += (x*2^SHIFT - acc) >>> SHIFT
        x_scaled = $signed({smp[SAMPLE_W-1], smp, {SHIFT{1'b0}}});
        acc_ext  = $signed({st_q.acc[ACC_W-1], st_q.acc});
        err      = x_scaled - acc_ext;
        step     = err >>> SHIFT;
        acc_sum  = acc_ext + step;

        // Integer part of the current estimate
        est_full = st_q.acc >>> SHIFT;
        est      = est_full[SUB_W-1:0];
        x_wide   = $signed({smp[SAMPLE_W-1], smp});
        diff     = x_wide - est;

        // Clamp to the signed SAMPLE_W range when the two top bits disagree
        if (diff[SUB_W-1] != diff[SUB_W-2]) begin
            clamped = {diff[SUB_W-1], {(SAMPLE_W-1){~diff[SUB_W-1]}}};
        end else begin
            clamped = diff[SAMPLE_W-1:0];
        end

        if (smp_valid) begin
            st_d.acc = acc_sum[ACC_W-1:0];
            st_d.res = en ? clamped : smp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;
endmodule

// File: rtl/dc_offset_canceller.sv
// Complex DC offset canceller: one independent estimator per rail.
module dc_offset_canceller #(
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned SHIFT    = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_i,
    output logic [SAMPLE_W-1:0] out_q
);
    import dcc_pkg::*;

    logic [SAMPLE_W-1:0] rail_in  [NUM_RAILS];
    logic [SAMPLE_W-1:0] rail_out [NUM_RAILS];

    assign rail_in[RAIL_I] = in_i;
    assign rail_in[RAIL_Q] = in_q;

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        dcc_rail #(
            .SAMPLE_W (SAMPLE_W),
            .SHIFT    (SHIFT)
        ) u_rail (
            .clk       (clk),
            .rst       (rst),
            .en        (en),
            .smp_valid (in_valid),
            .smp       (rail_in[r]),
            .res       (rail_out[r])
        );
    end

    logic vld_d, vld_q;

    always_comb begin
        vld_d = in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign out_valid = vld_q;
    assign out_i     = rail_out[RAIL_I];
    assign out_q     = rail_out[RAIL_Q];
endmodule

// File: rtl/dcc_chk.sv
// Port-level properties of the DC offset canceller.
module dcc_chk #(
    parameter int unsigned SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_i,
    input logic [SAMPLE_W-1:0] in_q,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_i,
    input logic [SAMPLE_W-1:0] out_q
);
    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R2
    bypass_i_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(en)) |-> (out_i == $past(in_i)));

    // R2
    bypass_q_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(en)) |-> (out_q == $past(in_q)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind dc_offset_canceller dcc_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_dc_offset_canceller.sv
module sim_dc_offset_canceller;
    localparam int CLK_PERIOD = 10;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic         out_valid;
    logic [W-1:0] out_i;
    logic [W-1:0] out_q;

    int checks = 0;
    int errors = 0;
    longint acc_i = 0;
    longint acc_q = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_offset_canceller u0 (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Expected enabled output per R4/R5
    function automatic longint model_out(input longint x, input longint a, input logic e);
        longint d;
        if (!e) return x;
        d = x - (a >>> 10);
        if (d > 8191) d = 8191;
        if (d < -8192) d = -8192;
        return d;
    endfunction

    // Estimator update per R3
    function automatic longint model_acc(input longint x, input longint a);
        return a + ((x * 1024 - a) >>> 10);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One valid sample pair; checks the result one clock later
    task automatic send(input longint xi, input longint xq, input logic e, input string req);
        longint ei, eq;
        in_valid = 1'b1;
        en = e;
        in_i = W'(xi);
        in_q = W'(xq);
        ei = model_out(xi, acc_i, e);
        eq = model_out(xq, acc_q, e);
        acc_i = model_acc(xi, acc_i);
        acc_q = model_acc(xq, acc_q);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", out_valid, 1);
        check(sx(out_i) == ei, req, sx(out_i), ei);
        check(sx(out_q) == eq, req, sx(out_q), eq);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        acc_i = 0;
        acc_q = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_i == '0, "R1", sx(out_i), 0);
        // R7: cleared estimate leaves the first enabled sample untouched
        send(1234, -777, 1'b1, "R7");
    endtask

    task automatic t_bypass();
        for (int k = 0; k < 20; k++) begin
            send(longint'(k * 811 - 8192), longint'(8191 - k * 433), 1'b0, "R2");
        end
        send(8191, -8192, 1'b0, "R2");
    endtask

    task automatic t_idle_hold();
        logic [W-1:0] li, lq;
        send(-4321, 2345, 1'b1, "R4");
        li = out_i;
        lq = out_q;
        in_valid = 1'b0;
        in_i = W'(5000);
        in_q = W'(-5000);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", out_valid, 0);
            check(out_i == li && out_q == lq, "R8", sx(out_i), sx(li));
        end
        // R3: idle cycles left the estimate untouched
        send(-4321, 2345, 1'b1, "R3");
    endtask

    task automatic t_track_independent();
        for (int k = 0; k < 9000; k++) begin
            send(3000, -2000, 1'b1, "R6");
        end
        check(sx(out_i) >= 0 && sx(out_i) <= 1, "R4", sx(out_i), 0);
        check(sx(out_q) >= 0 && sx(out_q) <= 1, "R4", sx(out_q), 0);
        // R6: stepping only I leaves Q settled
        send(-3000, -2000, 1'b1, "R6");
        check(sx(out_q) >= 0 && sx(out_q) <= 1, "R6", sx(out_q), 0);
    endtask

    task automatic t_learn_while_off();
        for (int k = 0; k < 9000; k++) begin
            send(500, -6000, 1'b0, "R2");
        end
        send(500, -6000, 1'b1, "R3");
        check(sx(out_i) >= 0 && sx(out_i) <= 1, "R3", sx(out_i), 0);
        check(sx(out_q) >= 0 && sx(out_q) <= 1, "R3", sx(out_q), 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 16000; k++) begin
            send(-8192, 8191, 1'b1, "R4");
        end
        send(8191, -8192, 1'b1, "R5");
        check(sx(out_i) == 8191, "R5", sx(out_i), 8191);
        check(sx(out_q) == -8192, "R5", sx(out_q), -8192);
    endtask

    task automatic t_reset_clears();
        do_reset();
        @(negedge clk);
        send(-100, 250, 1'b1, "R7");
        check(sx(out_i) == -100, "R7", sx(out_i), -100);
        check(sx(out_q) == 250, "R7", sx(out_q), 250);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_bypass();
        t_idle_hold();
        t_track_independent();
        t_learn_while_off();
        t_saturate();
        t_reset_clears();
        finish_run();
    end
endmodule